// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. Software writes a clock divisor, a target address (PHY number and register number) and then either launches a single read through a command register or launches a write simply by loading the write-data register. The block builds the serial frame and shifts it out on MDIO, timed by a management clock (MDC) that it derives from the system clock. Software polls a status register for busy, scan and data-not-valid flags.

In a read frame the block releases MDIO at the turnaround. If the PHY does not pull the line low in the second turnaround bit, the result is flagged as not valid. A scan mode re-reads the addressed register back to back, refreshing the read-data register after every frame, until software clears the scan bit.

Top module: `mdio_mgmt_ctrl`

Register indices (on `reg_wr_idx` / `reg_rd_idx`):

| Index | Register | Contents |
|---|---|---|
| 0 | divisor | bits 7:0 |
| 1 | command | bit 0 single read, bit 1 scan |
| 2 | address | register number in bits 4:0, PHY number in bits 12:8 |
| 3 | write data | bits 15:0 |
| 4 | read data | bits 15:0, read-only |
| 5 | status | bit 0 busy, bit 1 scanning, bit 2 not valid, read-only |

## Requirements
- R1: After reset, MDC is low, `mdio_oe` is low, and the status register (index 5) reads 0.
- R2: MDC runs continuously with a period of D system clocks, where D is the even value in the divisor register (index 0, bits 7:0). Divisor values below 2 behave as 2.
- R3: A bus write to the write-data register (index 3) launches a write frame. The frame carries the PHY number from address-register bits 12:8, the register number from bits 4:0, and the 16 written data bits.
- R4: Every frame is laid out in this order: 32 one bits, start code 01, opcode (10 for a read, 01 for a write), the PHY number MSB first, the register number MSB first, two turnaround bits, and 16 data bits MSB first. In a write frame the controller drives the turnaround as 10.
- R5: Writing the command register (index 1) with bit 0 set launches one read frame. At the end of that frame, the read-data register (index 4, bits 15:0) holds the 16 bits received.
- R6: A read whose second turnaround bit is not sampled low ends with status bit 2 set. A read that gets a low turnaround ends with status bit 2 cleared.
- R7: Status bit 0 is high from the launch request until the last data bit completes. It falls only on an MDC falling edge, and `mdio_oe` is low whenever the block is not busy.
- R8: A launch request (a read command or a write-data load) made while busy is ignored. No extra frame is sent.
- R9: With command bit 1 set, the block repeats read frames to the addressed register, holds status bit 1 high, and updates the read-data register after each frame.
- R10: Clearing command bit 1 stops scanning once the current frame ends. No further frames follow, and status bit 1 returns to 0.
- R11: In a read frame, `mdio_oe` is low from the first turnaround bit through the last data bit.
- R12: `mdio_o` changes only on a cycle in which MDC falls, so PHYs sample a stable value on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 3 | Index of register to write |
| reg_wr_data | input | 16 | Write value |
| reg_rd_idx | input | 3 | Index of register to read |
| reg_rd_data | output | 16 | Registered read value, valid one cycle after the index |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
A wrong bit counter or shift register shows up within one frame as a misplaced field that the PHY model decodes: wrong opcode, wrong address, or a preamble that is not 32 bits long. It also shows up as read data that is shifted by one or more positions. If the turnaround handling is broken, the controller either contends for the line during the PHY's data (caught at the first turnaround bit) or reports a wrong not-valid flag as soon as the read finishes. A stuck busy or scan flag is visible within one frame time as a frame that never ends, as frames that keep coming after scan is cleared, or as a second frame triggered by a request that should have been ignored.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  typedef enum logic [2:0] {
    IDX_DIV   = 3'd0,
    IDX_CMD   = 3'd1,
    IDX_ADDR  = 3'd2,
    IDX_WDATA = 3'd3,
    IDX_RDATA = 3'd4,
    IDX_STAT  = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic nv;
    logic scan;
    logic busy;
  } mgmt_status_t;

  localparam int PREAMBLE_BITS = 32;
  localparam int PHY_FIELD_LSB = 8;

  // Frame length: preamble + start(2) + op(2) + two addresses + turnaround(2) + data
  function automatic int frame_len(input int adr_w, input int data_w);
    return PREAMBLE_BITS + 6 + 2 * adr_w + data_w;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             tick_rise,
  output logic             tick_fall
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             tick;

  always_comb begin
    half = div >> 1;
    if (half == '0) tick = 1'b1;
    else            tick = (cnt >= half - 1'b1);
  end

  assign tick_rise = tick & ~mdc;
  assign tick_fall = tick & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int ADR_W  = 5,
  parameter int DATA_W = 16,
  localparam int FRAME = mdio_mgmt_pkg::frame_len(ADR_W, DATA_W),
  localparam int IDX_W = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              scan_en,
  input  logic [ADR_W-1:0]  phy,
  input  logic [ADR_W-1:0]  regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              scan_flag,
  output logic              nv,
  output logic [DATA_W-1:0] rdata,
  output logic              active,
  output logic              rd,
  output logic [IDX_W-1:0]  idx
);

  localparam int PRE      = mdio_mgmt_pkg::PREAMBLE_BITS;
  localparam int SH_W     = FRAME - PRE;
  localparam int LAST     = FRAME - 1;
  localparam int TA_POS   = PRE + 4 + 2 * ADR_W;
  localparam int DATA_POS = TA_POS + 2;

  logic              pend;
  logic              pend_rd;
  logic              ta_ok;
  logic [SH_W-1:0]   shreg;
  logic [DATA_W-1:0] rx;

  assign busy = pend | active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_rd   <= 1'b0;
      active    <= 1'b0;
      rd        <= 1'b0;
      idx       <= '0;
      shreg     <= '0;
      rx        <= '0;
      ta_ok     <= 1'b0;
      rdata     <= '0;
      nv        <= 1'b0;
      scan_flag <= 1'b0;
      mdio_o    <= 1'b1;
      mdio_oe   <= 1'b0;
    end else begin
      // launch requests are taken only while idle
      if (!busy) begin
        if (req_wr) begin
          pend    <= 1'b1;
          pend_rd <= 1'b0;
        end else if (req_rd || scan_en) begin
          pend    <= 1'b1;
          pend_rd <= 1'b1;
        end
      end

      // output side advances on MDC falling edges
      if (tick_fall) begin
        if (active) begin
          if (idx == IDX_W'(LAST)) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            if (rd) begin
              rdata <= rx;
              nv    <= ~ta_ok;
            end
            if (!scan_en) scan_flag <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
            if (idx >= IDX_W'(PRE - 1)) begin
              mdio_o <= shreg[SH_W-1];
              shreg  <= {shreg[SH_W-2:0], 1'b0};
            end
            mdio_oe <= ~(rd && (idx >= IDX_W'(TA_POS - 1)));
          end
        end else if (pend) begin
          active    <= 1'b1;
          pend      <= 1'b0;
          rd        <= pend_rd;
          idx       <= '0;
          mdio_o    <= 1'b1;
          mdio_oe   <= 1'b1;
          ta_ok     <= 1'b0;
          scan_flag <= scan_en & pend_rd;
          if (pend_rd) begin
            nv    <= 1'b1;
            shreg <= {2'b01, 2'b10, phy, regn, 2'b11, {DATA_W{1'b0}}};
          end else begin
            shreg <= {2'b01, 2'b01, phy, regn, 2'b10, wdata};
          end
        end
      end

      // input side samples on MDC rising edges
      if (tick_rise && active && rd) begin
        if (idx == IDX_W'(DATA_POS - 1)) ta_ok <= ~mdio_i;
        if (idx >= IDX_W'(DATA_POS))     rx    <= {rx[DATA_W-2:0], mdio_i};
      end
    end
  end

endmodule

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADR_W  = 5,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16,
  parameter int IDX_B  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_B-1:0]  wr_idx,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [IDX_B-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rdata_in,
  input  mgmt_status_t      st,
  output logic [DIV_W-1:0]  div_q,
  output logic              scan_en,
  output logic [ADR_W-1:0]  phy_q,
  output logic [ADR_W-1:0]  regn_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              req_rd,
  output logic              req_wr,
  output logic [BUS_W-1:0]  rd_data
);

  localparam int GAP_W = PHY_FIELD_LSB - ADR_W;

  logic [1:0] cmd_q;

  assign scan_en = cmd_q[1];
  assign req_rd  = wr_en && (reg_idx_e'(wr_idx) == IDX_CMD) && wr_data[0];
  assign req_wr  = wr_en && (reg_idx_e'(wr_idx) == IDX_WDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(2);
      cmd_q   <= '0;
      phy_q   <= '0;
      regn_q  <= '0;
      wdata_q <= '0;
    end else if (wr_en) begin
      case (reg_idx_e'(wr_idx))
        IDX_DIV:   div_q   <= wr_data[DIV_W-1:0];
        IDX_CMD:   cmd_q   <= wr_data[1:0];
        IDX_ADDR: begin
          regn_q <= wr_data[ADR_W-1:0];
          phy_q  <= wr_data[PHY_FIELD_LSB +: ADR_W];
        end
        IDX_WDATA: wdata_q <= wr_data[DATA_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_idx_e'(rd_idx))
        IDX_DIV:   rd_data <= BUS_W'(div_q);
        IDX_CMD:   rd_data <= BUS_W'(cmd_q);
        IDX_ADDR:  rd_data <= BUS_W'({phy_q, {GAP_W{1'b0}}, regn_q});
        IDX_WDATA: rd_data <= BUS_W'(wdata_q);
        IDX_RDATA: rd_data <= BUS_W'(rdata_in);
        IDX_STAT:  rd_data <= BUS_W'(st);
        default:   rd_data <= '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int ADR_W  = 5,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16,
  parameter int IDX_B  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [IDX_B-1:0] reg_wr_idx,
  input  logic [BUS_W-1:0] reg_wr_data,
  input  logic [IDX_B-1:0] reg_rd_idx,
  output logic [BUS_W-1:0] reg_rd_data,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  localparam int FRAME_LEN = frame_len(ADR_W, DATA_W);
  localparam int IDX_W     = $clog2(FRAME_LEN);

  logic [DIV_W-1:0]  div_q;
  logic              scan_en, req_rd, req_wr;
  logic [ADR_W-1:0]  phy_q, regn_q;
  logic [DATA_W-1:0] wdata_q, rdata;
  logic              tick_rise, tick_fall;
  logic              st_busy, st_scan, st_nv;
  logic              frm_active, frm_rd;
  logic [IDX_W-1:0]  frm_idx;
  mgmt_status_t      status;

  assign status = '{nv: st_nv, scan: st_scan, busy: st_busy};

  mdio_cfg_regs #(
    .DIV_W(DIV_W), .ADR_W(ADR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .IDX_B(IDX_B)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
    .rd_idx(reg_rd_idx), .rdata_in(rdata), .st(status),
    .div_q(div_q), .scan_en(scan_en), .phy_q(phy_q), .regn_q(regn_q),
    .wdata_q(wdata_q), .req_rd(req_rd), .req_wr(req_wr), .rd_data(reg_rd_data)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk(clk), .rst(rst), .div(div_q),
    .mdc(mdc), .tick_rise(tick_rise), .tick_fall(tick_fall)
  );

  mdio_frame_engine #(.ADR_W(ADR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .tick_rise(tick_rise), .tick_fall(tick_fall),
    .req_rd(req_rd), .req_wr(req_wr), .scan_en(scan_en),
    .phy(phy_q), .regn(regn_q), .wdata(wdata_q), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(st_busy), .scan_flag(st_scan),
    .nv(st_nv), .rdata(rdata), .active(frm_active), .rd(frm_rd), .idx(frm_idx)
  );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
  parameter int IDX_W  = 6,
  parameter int TA_POS = 46
) (
  input logic             clk,
  input logic             rst,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             busy,
  input logic             active,
  input logic             rd,
  input logic [IDX_W-1:0] idx
);

  // R7: line released whenever no transaction is pending or running
  p_idle_release_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R7: busy ends only together with an MDC falling edge
  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $fell(mdc));

  // R11: no drive from turnaround onwards in a read frame
  p_ta_release_r11: assert property (@(posedge clk) disable iff (rst)
    (active && rd && (idx >= IDX_W'(TA_POS))) |-> !mdio_oe);

  // R12: data output moves only with MDC falling
  p_mdio_edge_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> $fell(mdc));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(
  .IDX_W(IDX_W),
  .TA_POS(mdio_mgmt_pkg::PREAMBLE_BITS + 4 + 2 * ADR_W)
) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(st_busy), .active(frm_active), .rd(frm_rd), .idx(frm_idx)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
module mdio_mgmt_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY_ID = 5'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [15:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_idx = '0;
  logic [15:0] reg_rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0;
  logic        phy_val = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_mgmt_ctrl u_mdio_mgmt_ctrl (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- PHY model with write scoreboard ----------------
  logic [15:0] phy_mem [32];
  logic [25:0] exp_q [$];
  int          frames = 0;
  int          ones = 0;
  int          pos = 0;
  logic [30:0] sh = '0;
  bit          f_rd = 0;
  logic [4:0]  f_phy = '0, f_reg = '0;

  always @(posedge mdc) begin
    if (pos == 0) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        check(ones == 32, "R4 preamble length", ones, 32);
        pos = 33; sh = '0; f_rd = 0;
      end else ones = 0;
    end else begin
      sh = {sh[29:0], mdio_o};
      if (f_rd && pos >= 46) check(!mdio_oe, "R11 line released in read", mdio_oe, 0);
      if (pos == 45) begin
        check(sh[12] == 1'b1, "R4 start code", sh[12], 1);
        check(sh[11:10] == 2'b10 || sh[11:10] == 2'b01, "R4 opcode", sh[11:10], 2);
        f_rd  = (sh[11:10] == 2'b10);
        f_phy = sh[9:5];
        f_reg = sh[4:0];
      end
      if (pos == 63) begin
        frames++;
        if (!f_rd) begin
          check(sh[17:16] == 2'b10, "R4 write turnaround", sh[17:16], 2);
          if (f_phy == PHY_ID) phy_mem[f_reg] = sh[15:0];
          if (exp_q.size() == 0) begin
            check(0, "R8 unexpected write frame", {f_phy, f_reg, sh[15:0]}, 0);
          end else begin
            logic [25:0] e;
            e = exp_q.pop_front();
            check({f_phy, f_reg, sh[15:0]} == e, "R3 write frame fields",
                  {f_phy, f_reg, sh[15:0]}, e);
          end
        end
        pos = 0; ones = 0;
      end else pos++;
    end
  end

  always @(negedge mdc) begin
    if (pos >= 47 && f_rd && f_phy == PHY_ID) begin
      phy_en  = 1'b1;
      phy_val = (pos == 47) ? 1'b0 : phy_mem[f_reg][63 - pos];
    end else begin
      phy_en  = 1'b0;
      phy_val = 1'b1;
    end
  end

  // R12 monitor: mdio_o may only move on a cycle where mdc falls
  int   edge_viol = 0;
  logic prev_o = 1'b1, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (!rst && mdio_o != prev_o && !(prev_mdc && !mdc)) edge_viol++;
    prev_o = mdio_o; prev_mdc = mdc;
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input logic [2:0] i, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = i; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] i, output logic [15:0] d);
    @(negedge clk);
    reg_rd_idx = i;
    @(negedge clk);
    d = reg_rd_data;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int n = 0; n < 3000; n++) begin
      bus_rd(3'd5, s);
      if (!s[0]) return;
    end
    check(0, "R7 busy never cleared", 1, 0);
  endtask

  task automatic drive_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    exp_q.push_back({p, r, d});
    bus_wr(3'd2, {3'b000, p, 3'b000, r});
    bus_wr(3'd3, d);
  endtask

  task automatic measure_mdc(output int n);
    logic pm;
    n = 0;
    pm = mdc;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (mdc && !pm) break;
      pm = mdc;
    end
    pm = mdc;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      n++;
      if (mdc && !pm) break;
      pm = mdc;
    end
  endtask

  task automatic wait_frames(input int target);
    for (int k = 0; k < 5000 && frames < target; k++) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] v;
    int n, f0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1000 + 16'(i * 16'h0111);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(mdc == 1'b0, "R1 mdc after reset", mdc, 0);
    check(mdio_oe == 1'b0, "R1 oe after reset", mdio_oe, 0);
    bus_rd(3'd5, v);
    check(v == 16'h0, "R1 status after reset", v, 0);

    bus_wr(3'd0, 16'd4);
    measure_mdc(n);
    check(n == 4, "R2 mdc period div 4", n, 4);
    bus_wr(3'd0, 16'd6);
    measure_mdc(n);
    check(n == 6, "R2 mdc period div 6", n, 6);
    bus_wr(3'd0, 16'd4);

    // R3 / R7 write
    drive_write(PHY_ID, 5'd3, 16'hA5C3);
    bus_rd(3'd5, v);
    check(v[0] == 1'b1, "R7 busy after launch", v[0], 1);
    wait_idle();
    check(phy_mem[3] == 16'hA5C3, "R3 PHY register written", phy_mem[3], 16'hA5C3);
    check(frames == 1, "R3 one frame", frames, 1);

    // R5 read
    bus_wr(3'd2, {8'd0 | 8'(PHY_ID), 8'd3});
    bus_wr(3'd1, 16'h1);
    wait_idle();
    bus_rd(3'd4, v);
    check(v == 16'hA5C3, "R5 read data", v, 16'hA5C3);
    bus_rd(3'd5, v);
    check(v == 16'h0, "R6 nv clear after good read", v, 0);

    bus_wr(3'd2, {8'(PHY_ID), 8'd17});
    bus_wr(3'd1, 16'h1);
    wait_idle();
    bus_rd(3'd4, v);
    check(v == phy_mem[17], "R5 read data reg 17", v, phy_mem[17]);

    // R6 absent PHY
    bus_wr(3'd2, {8'd9, 8'd2});
    bus_wr(3'd1, 16'h1);
    wait_idle();
    bus_rd(3'd5, v);
    check(v == 16'h4, "R6 nv set on absent PHY", v, 4);
    bus_wr(3'd2, {8'(PHY_ID), 8'd4});
    bus_wr(3'd1, 16'h1);
    wait_idle();
    bus_rd(3'd5, v);
    check(v[2] == 1'b0, "R6 nv cleared by next good read", v[2], 0);
    bus_rd(3'd4, v);
    check(v == phy_mem[4], "R5 read data reg 4", v, phy_mem[4]);

    // R8 requests while busy are dropped
    f0 = frames;
    v = phy_mem[8];
    drive_write(PHY_ID, 5'd7, 16'h3C5A);
    repeat (30) @(negedge clk);
    bus_wr(3'd2, {8'(PHY_ID), 8'd8});
    bus_wr(3'd3, 16'hDEAD);
    bus_wr(3'd1, 16'h1);
    wait_idle();
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R8 single frame", frames, f0 + 1);
    check(phy_mem[8] == v, "R8 ignored write left reg 8", phy_mem[8], v);
    check(phy_mem[7] == 16'h3C5A, "R8 first write done", phy_mem[7], 16'h3C5A);

    // R9 scan
    phy_mem[20] = 16'h1357;
    bus_wr(3'd2, {8'(PHY_ID), 8'd20});
    bus_wr(3'd1, 16'h2);
    f0 = frames;
    wait_frames(f0 + 2);
    bus_rd(3'd5, v);
    check(v[1] == 1'b1, "R9 scan flag", v[1], 1);
    bus_rd(3'd4, v);
    check(v == 16'h1357, "R9 scan data", v, 16'h1357);
    phy_mem[20] = 16'hBEEF;
    wait_frames(frames + 2);
    check(frames >= f0 + 4, "R9 repeated frames", frames, f0 + 4);
    bus_rd(3'd4, v);
    check(v == 16'hBEEF, "R9 scan data refreshed", v, 16'hBEEF);

    // R10 stop scan
    bus_wr(3'd1, 16'h0);
    wait_idle();
    f0 = frames;
    repeat (600) @(negedge clk);
    check(frames == f0, "R10 no frames after scan cleared", frames, f0);
    bus_rd(3'd5, v);
    check(v[1:0] == 2'b00, "R10 scan and busy low", v[1:0], 0);

    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    check(edge_viol == 0, "R12 mdio moves only on mdc fall", edge_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule